// File: doc/BRIEF.md
# Ultra DMA device burst controller

This block runs the device end of Ultra DMA bursts on a parallel ATA cable. When internal logic asks for a transfer, the block raises its DMA request. It waits until the host has asserted the acknowledge and released the stop line, and then opens a burst in the direction chosen at request time. The two host strobe pins and the device ready pin change meaning during a burst, and the block drives or interprets them according to that direction. The burst ends when the host asserts stop. The block then drops the request and parks its strobe at the idle level. It does not return to idle until the host withdraws the acknowledge.

When the device sends, each word goes onto the bus data lines one clock before the device strobe changes level. Both rising and falling strobe edges count, and at most one word moves every two clocks. When the host holds its ready line negated, the device strobe stops after a short bounded overrun, and that bound is a parameter. When the host sends, the device drives its active-low ready and stores one word on every edge of the host strobe into a small receive queue. It negates ready once the queue comes within a fixed slack of full. Words move to and from internal logic through valid/ready handshakes. All bus inputs are taken to be synchronous to the block clock. Checksums and electrical timing are handled outside this block.

Top module: `udma_dev_burst`

## Requirements
- R1: While reset is held and on the first cycle after it, `dma_req`=0, `bus_dout_en`=0, `dev_strb_rdy_n`=1 and `rx_valid`=0.
- R2: A `xfer_req` sampled high while idle raises `dma_req` one clock later. The direction is latched at the same edge: `xfer_to_host`=1 means device-to-host and 0 means host-to-device.
- R3: A burst opens only at an edge where `dma_ack_n`=0 and `bus_stop`=0 are both sampled. Until then `bus_dout_en` stays 0 and no word is taken from `tx_data`.
- R4: In a device-to-host burst, a word taken from `tx_data` (`tx_valid`&&`tx_ready`) appears on `bus_dout` one clock before `dev_strb_rdy_n` toggles. Every toggle, rising or falling, carries the next word in order. The first toggle is a fall from 1. With the host ready and data always available, words follow one every two clocks.
- R5: In a device-to-host burst, while `host_strb_rdy_n` is sampled 1, at most PAUSE_LAG further words are taken and at most PAUSE_LAG+1 strobe toggles follow. After that the strobe holds still until `host_strb_rdy_n` returns to 0, and toggling then resumes.
- R6: In a host-to-device burst, `dev_strb_rdy_n` is 0 exactly while the receive occupancy is below RX_DEPTH-RX_SLACK. It is 1 when occupancy reaches that level and at all times outside a burst.
- R7: In a host-to-device burst, every change of `host_strb_rdy_n` seen between consecutive clock samples stores `bus_din`. Stored words leave on `rx_data`/`rx_valid` in arrival order, one per cycle with `rx_ready`=1.
- R8: Sampling `bus_stop`=1 in a burst ends it. A word already placed on `bus_dout` still gets its strobe toggle before the end, so every word taken is delivered. `dma_req` then falls, `bus_dout_en` falls, and `dev_strb_rdy_n` returns to 1.
- R9: A host strobe edge sampled at the same edge as `bus_stop`=1 is still stored and delivered on the receive port.
- R10: After a burst ends, `dma_req` stays 0 and `xfer_req` is ignored while `dma_ack_n` is sampled 0. Once `dma_ack_n`=1 is sampled, the block is idle, and a pending `xfer_req` raises `dma_req` two clocks after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_req | input | 1 | Internal request to run a burst |
| xfer_to_host | input | 1 | Direction for the next burst, 1 = device sends |
| tx_data | input | W | Word to send to the host |
| tx_valid | input | 1 | `tx_data` holds a word |
| tx_ready | output | 1 | Word taken this cycle |
| rx_data | output | W | Oldest received word |
| rx_valid | output | 1 | Receive queue not empty |
| rx_ready | input | 1 | Consumer takes `rx_data` this cycle |
| dma_req | output | 1 | DMA request toward the host |
| dma_ack_n | input | 1 | Host DMA acknowledge, active low |
| bus_stop | input | 1 | Write strobe pin, used as burst stop |
| host_strb_rdy_n | input | 1 | Read strobe pin: host ready (device sends) or host strobe (host sends) |
| dev_strb_rdy_n | output | 1 | Ready pin: device strobe (device sends) or device ready, active low (host sends) |
| bus_din | input | W | Data lines from the host |
| bus_dout | output | W | Data lines toward the host |
| bus_dout_en | output | 1 | Drive enable for `bus_dout` |

## Verification
Two pairs of functions can fall on one edge. In the first, termination meets the last data edge. The bench asserts stop together with a final host strobe toggle and expects that word at the receive port. It also asserts stop at both phases of the two-cycle send sequence and requires every word taken from `tx_data` to have had a strobe toggle. In the second, the throttle meets a word already under way. The bench negates host ready at six different offsets within the send rhythm and bounds the overrun arithmetically by PAUSE_LAG+1 toggles. A receive sweep slows the consumer in four steps and compares the device ready pin every cycle against an occupancy the bench tracks from its own pushes and pops.

// File: rtl/udma_burst_pkg.sv
package udma_burst_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_BURST, ST_TERM} burst_st_e;

  // receive queue is within slack of full
  function automatic logic rx_nearly_full(input int unsigned occ,
                                          input int unsigned depth,
                                          input int unsigned slack);
    return (occ + slack) >= depth;
  endfunction

  // a new outgoing word may start
  function automatic logic pause_allows(input logic host_rdy_n,
                                        input int unsigned lag_used,
                                        input int unsigned lag_max);
    return !host_rdy_n || (lag_used < lag_max);
  endfunction
endpackage

// File: rtl/udma_burst_fsm.sv
module udma_burst_fsm
  import udma_burst_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      xfer_req,
  input  logic      xfer_to_host,
  input  logic      dma_ack_n,
  input  logic      bus_stop,
  input  logic      launch_pending,
  output burst_st_e st,
  output logic      dir_tx,
  output logic      dma_req
);
  burst_st_e st_nx;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:  if (xfer_req) st_nx = ST_REQ;
      ST_REQ:   if (!dma_ack_n && !bus_stop) st_nx = ST_BURST;
      ST_BURST: if (bus_stop && !launch_pending) st_nx = ST_TERM;
      ST_TERM:  if (dma_ack_n) st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      dir_tx <= 1'b1;
    end else begin
      st <= st_nx;
      if (st == ST_IDLE && xfer_req) dir_tx <= xfer_to_host;
    end
  end

  assign dma_req = (st == ST_REQ) || (st == ST_BURST);

  // R3
  burst_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BURST && $past(st) != ST_BURST) |-> $past(!dma_ack_n && !bus_stop));
  // R8
  burst_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TERM && $past(st) == ST_BURST) |-> $past(bus_stop));
  // R10
  term_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && $past(st) == ST_TERM) |-> $past(dma_ack_n));
endmodule

// File: rtl/udma_tx_launch.sv
module udma_tx_launch
  import udma_burst_pkg::*;
#(
  parameter int W = 16,
  parameter int PAUSE_LAG = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         bus_stop,
  input  logic         host_rdy_n,
  input  logic [W-1:0] tx_data,
  input  logic         tx_valid,
  output logic         tx_ready,
  output logic [W-1:0] dout,
  output logic         strobe,
  output logic         pending
);
  localparam int LW = $clog2(PAUSE_LAG + 1) + 1;

  logic          ph;
  logic [LW-1:0] lag_used;
  logic          launch;

  assign launch   = active && !ph && !bus_stop && tx_valid &&
                    pause_allows(host_rdy_n, 32'(lag_used), PAUSE_LAG);
  assign tx_ready = launch;
  assign pending  = ph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= 1'b0;
      strobe <= 1'b1;
      dout   <= '0;
    end else if (launch) begin
      dout <= tx_data;
      ph   <= 1'b1;
    end else if (ph) begin
      strobe <= ~strobe;
      ph     <= 1'b0;
    end else if (!active) begin
      strobe <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !active || !host_rdy_n) lag_used <= '0;
    else if (launch) lag_used <= lag_used + 1'b1;
  end

  // R4
  launch_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !launch);
  // R4
  strobe_after_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(active) && strobe != $past(strobe)) |-> $past(ph));
  // R5
  pause_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rdy_n && $past(host_rdy_n) && lag_used == LW'(PAUSE_LAG)) |-> !launch);
endmodule

// File: rtl/udma_rx_capture.sv
module udma_rx_capture
  import udma_burst_pkg::*;
#(
  parameter int W = 16,
  parameter int RX_DEPTH = 8,
  parameter int RX_SLACK = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         host_strb,
  input  logic [W-1:0] din,
  input  logic         rx_ready,
  output logic [W-1:0] rx_data,
  output logic         rx_valid,
  output logic         near_full
);
  localparam int AW = $clog2(RX_DEPTH);
  localparam int CW = $clog2(RX_DEPTH + 1);

  logic [W-1:0]  mem [RX_DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] occ;
  logic          hs_q;
  logic          strb_edge, push, pop;

  assign strb_edge = host_strb ^ hs_q;
  assign push      = active && strb_edge;
  assign pop       = rx_valid && rx_ready;
  assign rx_valid  = (occ != '0);
  assign rx_data   = mem[rd_ptr];
  assign near_full = rx_nearly_full(32'(occ), RX_DEPTH, RX_SLACK);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q   <= 1'b1;
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      hs_q <= host_strb;
      if (push) wr_ptr <= (wr_ptr == AW'(RX_DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(RX_DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      occ <= occ + CW'(push) - CW'(pop);
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (occ < CW'(RX_DEPTH)));
  // R6
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && occ == CW'(RX_DEPTH - RX_SLACK - 1) && !pop) |=> near_full);
endmodule

// File: rtl/udma_dev_burst.sv
module udma_dev_burst
  import udma_burst_pkg::*;
#(
  parameter int W = 16,
  parameter int PAUSE_LAG = 2,
  parameter int RX_DEPTH = 8,
  parameter int RX_SLACK = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         xfer_req,
  input  logic         xfer_to_host,
  input  logic [W-1:0] tx_data,
  input  logic         tx_valid,
  output logic         tx_ready,
  output logic [W-1:0] rx_data,
  output logic         rx_valid,
  input  logic         rx_ready,
  output logic         dma_req,
  input  logic         dma_ack_n,
  input  logic         bus_stop,
  input  logic         host_strb_rdy_n,
  output logic         dev_strb_rdy_n,
  input  logic [W-1:0] bus_din,
  output logic [W-1:0] bus_dout,
  output logic         bus_dout_en
);
  burst_st_e st;
  logic dir_tx, pending, tx_strobe, near_full;
  logic tx_active, rx_active;

  assign tx_active = (st == ST_BURST) && dir_tx;
  assign rx_active = (st == ST_BURST) && !dir_tx;

  udma_burst_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .xfer_to_host(xfer_to_host),
    .dma_ack_n(dma_ack_n), .bus_stop(bus_stop), .launch_pending(pending),
    .st(st), .dir_tx(dir_tx), .dma_req(dma_req)
  );

  udma_tx_launch #(.W(W), .PAUSE_LAG(PAUSE_LAG)) tx_i (
    .clk(clk), .rst_n(rst_n), .active(tx_active), .bus_stop(bus_stop),
    .host_rdy_n(host_strb_rdy_n), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .dout(bus_dout), .strobe(tx_strobe), .pending(pending)
  );

  udma_rx_capture #(.W(W), .RX_DEPTH(RX_DEPTH), .RX_SLACK(RX_SLACK)) rx_i (
    .clk(clk), .rst_n(rst_n), .active(rx_active), .host_strb(host_strb_rdy_n),
    .din(bus_din), .rx_ready(rx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .near_full(near_full)
  );

  assign dev_strb_rdy_n = dir_tx ? tx_strobe : !(rx_active && !near_full);
  assign bus_dout_en    = tx_active;

  // R8
  strobe_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TERM && $past(st) == ST_TERM) |-> dev_strb_rdy_n);
endmodule

// File: tb/udma_dev_burst_tb_top.sv
`timescale 1ns/1ps
module udma_dev_burst_tb_top;
  localparam int W = 16, LAG = 2, DEPTH = 8, SLACK = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, xfer_req, xfer_to_host, tx_valid, tx_ready, rx_valid, rx_ready;
  logic dma_req, dma_ack_n, bus_stop, host_strb_rdy_n, dev_strb_rdy_n, bus_dout_en;
  logic [W-1:0] tx_data, rx_data, bus_din, bus_dout;

  udma_dev_burst #(.W(W), .PAUSE_LAG(LAG), .RX_DEPTH(DEPTH), .RX_SLACK(SLACK)) dut_i (
    .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .xfer_to_host(xfer_to_host),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .dma_req(dma_req), .dma_ack_n(dma_ack_n), .bus_stop(bus_stop),
    .host_strb_rdy_n(host_strb_rdy_n), .dev_strb_rdy_n(dev_strb_rdy_n),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en)
  );

  int vecs = 0, errs = 0;
  int tx_cnt = 0, exp_w = 0, tx_edges = 0;
  int exp_rx = 0, sent = 0, mcount = 0, cyc = 0, cons_div = 1, nf_seen = 0, wd = 0;
  bit cons_on = 0, push_pend = 0, prev_strb = 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] tx_word(input int i); return W'(i) ^ 16'h5A00; endfunction
  function automatic logic [W-1:0] rx_word(input int i); return W'(i * 3) ^ 16'hC000; endfunction

  assign tx_data = tx_word(tx_cnt);

  // word source and bench occupancy model
  always @(posedge clk) begin
    if (tx_valid && tx_ready) tx_cnt <= tx_cnt + 1;
    mcount <= mcount + (push_pend ? 1 : 0) - ((rx_valid && rx_ready) ? 1 : 0);
  end

  // host-side strobe monitor for device-to-host words (R4)
  always @(negedge clk) begin
    if (bus_dout_en && (dev_strb_rdy_n != prev_strb)) begin
      chk(bus_dout == tx_word(exp_w), "R4 word on strobe edge", int'(bus_dout), int'(tx_word(exp_w)));
      exp_w++;
      tx_edges++;
    end
    prev_strb = dev_strb_rdy_n;
  end

  // receive consumer (R7)
  always @(negedge clk) begin
    cyc++;
    if (cons_on && rx_valid && (cyc % cons_div == 0)) begin
      chk(rx_data == rx_word(exp_rx), "R7 receive order", int'(rx_data), int'(rx_word(exp_rx)));
      exp_rx++;
      rx_ready = 1'b1;
    end else begin
      rx_ready = 1'b0;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      errs++;
      $display("FAIL watchdog R7/R8 stalled act=%0d exp=%0d", wd, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    int e0, e1;
    rst_n = 0; xfer_req = 0; xfer_to_host = 1; tx_valid = 0;
    dma_ack_n = 1; bus_stop = 1; host_strb_rdy_n = 1; bus_din = '0;
    repeat (3) @(negedge clk);
    chk(dma_req == 0 && bus_dout_en == 0, "R1 reset outputs", int'(dma_req), 0);
    rst_n = 1;
    @(negedge clk);
    chk(dma_req == 0, "R1 dma_req", int'(dma_req), 0);
    chk(dev_strb_rdy_n == 1, "R1 ready pin", int'(dev_strb_rdy_n), 1);
    chk(rx_valid == 0 && bus_dout_en == 0, "R1 rx_valid/oe", int'(rx_valid), 0);

    // device-to-host
    xfer_req = 1;
    @(negedge clk);
    chk(dma_req == 1, "R2 request raised", int'(dma_req), 1);
    xfer_req = 0; dma_ack_n = 0; tx_valid = 1; host_strb_rdy_n = 0;
    repeat (4) begin
      @(negedge clk);
      chk(bus_dout_en == 0, "R3 no burst while stop high", int'(bus_dout_en), 0);
      chk(tx_cnt == 0, "R3 no word taken", tx_cnt, 0);
    end
    bus_stop = 0;
    repeat (20) @(negedge clk);
    chk(tx_edges == 9, "R4 two-clock rhythm", tx_edges, 9);

    for (int k = 0; k < 6; k++) begin
      repeat (k) @(negedge clk);
      host_strb_rdy_n = 1;
      e0 = tx_edges;
      repeat (12) @(negedge clk);
      chk(tx_edges - e0 <= LAG + 1, "R5 overrun bound", tx_edges - e0, LAG + 1);
      e1 = tx_edges;
      repeat (4) @(negedge clk);
      chk(tx_edges == e1, "R5 strobe held", tx_edges, e1);
      host_strb_rdy_n = 0;
      repeat (6) @(negedge clk);
      chk(tx_edges > e1, "R5 resume", tx_edges, e1 + 1);
    end

    for (int k = 0; k < 2; k++) begin
      repeat (6 + k) @(negedge clk);
      bus_stop = 1;
      repeat (4) @(negedge clk);
      chk(dma_req == 0, "R8 request dropped", int'(dma_req), 0);
      chk(bus_dout_en == 0, "R8 bus released", int'(bus_dout_en), 0);
      chk(dev_strb_rdy_n == 1, "R8 strobe parked", int'(dev_strb_rdy_n), 1);
      chk(exp_w == tx_cnt, "R8 no lost word", exp_w, tx_cnt);
      xfer_to_host = (k == 0);
      xfer_req = 1;
      repeat (5) begin
        @(negedge clk);
        chk(dma_req == 0, "R10 held until ack released", int'(dma_req), 0);
      end
      dma_ack_n = 1;
      repeat (2) @(negedge clk);
      chk(dma_req == 1, "R10 new request", int'(dma_req), 1);
      xfer_req = 0;
      if (k == 0) begin
        dma_ack_n = 0; bus_stop = 0;
      end
    end

    // host-to-device
    host_strb_rdy_n = 1;
    @(negedge clk);
    chk(dev_strb_rdy_n == 1, "R6 ready high outside burst", int'(dev_strb_rdy_n), 1);
    dma_ack_n = 0; bus_stop = 0; cons_on = 1;
    for (int d = 1; d <= 4; d++) begin
      cons_div = d;
      for (int n = 0; n < 24; ) begin
        @(negedge clk);
        chk(dev_strb_rdy_n == (mcount >= DEPTH - SLACK), "R6 ready vs occupancy",
            int'(dev_strb_rdy_n), int'(mcount >= DEPTH - SLACK));
        if (dev_strb_rdy_n) nf_seen++;
        if (!dev_strb_rdy_n) begin
          host_strb_rdy_n = ~host_strb_rdy_n; bus_din = rx_word(sent);
          push_pend = 1; sent++; n++;
        end else push_pend = 0;
      end
      @(negedge clk); push_pend = 0;
      while (exp_rx < sent) @(negedge clk);
      chk(exp_rx == sent, "R7 all words delivered", exp_rx, sent);
    end
    chk(nf_seen > 0, "R6 ready negated when nearly full", nf_seen, 1);

    @(negedge clk);
    host_strb_rdy_n = ~host_strb_rdy_n; bus_din = rx_word(sent);
    push_pend = 1; sent++; bus_stop = 1;
    @(negedge clk); push_pend = 0;
    repeat (6) @(negedge clk);
    chk(exp_rx == sent, "R9 edge with stop kept", exp_rx, sent);
    chk(dma_req == 0 && dev_strb_rdy_n == 1, "R8 receive burst ended", int'(dma_req), 0);
    dma_ack_n = 1;
    repeat (2) @(negedge clk);
    chk(dma_req == 0, "R10 idle after release", int'(dma_req), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule